// File: doc/BRIEF.md
# Accumulator Arithmetic Unit

This block computes the next value of the accumulator in a machine built around one accumulator register. On each cycle with a valid request, it takes the current accumulator, a register operand and an 8-bit immediate byte. A group select and a 3-bit function code choose the operation. The result appears on a register one clock later. The caller writes it back into the accumulator.

There are four operation groups: single-operand operations, accumulator-with-register operations, an unsigned less-than compare, and immediate operations. The machine has no flag register. Carry and borrow are recovered with the compare, which leaves 0 or 1 in the accumulator. For example, after an add, comparing the sum with the addend gives the carry out. The data width is a parameter, default 8. Every arithmetic result wraps modulo 2^W.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high, the next clock edge clears `res_o` to 0 and `res_valid_o` to 0.
- R2: A request taken with `valid_i` high shows its result on `res_o` at the next rising edge, with `res_valid_o` high. A cycle with `valid_i` low drops `res_valid_o` on the next edge and leaves `res_o` unchanged.
- R3: Group 0 (single operand) uses `fn_i` 0..7 to select: 0 zero, 1 shift left by one, 2 logical shift right by one, 3 arithmetic shift right by one, 4 increment, 5 decrement, 6 bitwise complement, 7 two's-complement negate.
- R4: Group 1 (register) uses `fn_i` 0..4 to select accumulator plus operand, accumulator minus operand, AND, OR and XOR. Add and subtract wrap modulo 2^W.
- R5: Group 1 uses `fn_i` 5, 6 and 7 to shift the accumulator left, logical right and arithmetic right by the value of `opnd_i`. A shift amount of W or more gives 0, except for the arithmetic right shift, which fills every bit with the accumulator's sign bit.
- R6: Group 2 writes 1 when the accumulator is unsigned-less-than `opnd_i` and 0 otherwise.
- R7: Group 3 uses `fn_i[1:0]` values 0, 1 and 2 to select AND, OR and XOR of the accumulator with `imm_i` zero-extended to W bits.
- R8: Group 3 with `fn_i[1:0]`=3 and `imm_i[7]`=0 adds `imm_i[6:0]`, zero-extended, to the accumulator.
- R9: Group 3 with `fn_i[1:0]`=3 and `imm_i[7:6]`=2'b11 adds `imm_i[5:0]`, sign-extended, to the accumulator.
- R10: Group 3 with `fn_i[1:0]`=3 and `imm_i[7:5]`=3'b100 shifts the accumulator by the amount in `imm_i[2:0]`. The kind comes from `imm_i[4:3]`: 0 rotate left, 1 shift left, 2 logical shift right, 3 arithmetic shift right.
- R11: Group 3 with `fn_i[1:0]`=3 and `imm_i[7:5]`=3'b101 is an unused encoding, and the accumulator passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Request strobe |
| grp_i | input | 2 | Group: 0 single operand, 1 register, 2 compare, 3 immediate |
| fn_i | input | 3 | Function code within the group |
| acc_i | input | W | Current accumulator |
| opnd_i | input | W | Register operand |
| imm_i | input | 8 | Immediate byte |
| res_o | output | W | Registered new accumulator value |
| res_valid_o | output | 1 | High one cycle after an accepted request |

## Verification
The bench drives the compare with equal operands and with the accumulator's top bit set. A signed compare would return 1 where the correct answer is 0, and an off-by-one compare would flag equality. Register shifts are driven with amounts of exactly W and far above W, where a design that truncates the amount would return a shifted value instead of 0 or sign fill. On the immediate side, the bench targets the two add encodings with the most negative six-bit field and with seven-bit 127. It also covers rotate by 0 and 7 and the unused encoding; a decoder that mixes these up would add the wrong constant or corrupt the pass-through value.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [1:0] {
    GRP_UNARY = 2'd0,
    GRP_REG   = 2'd1,
    GRP_CMP   = 2'd2,
    GRP_IMM   = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    UN_ZERO = 3'd0, UN_SHL1 = 3'd1, UN_SHR1 = 3'd2, UN_SAR1 = 3'd3,
    UN_INC  = 3'd4, UN_DEC  = 3'd5, UN_NOT  = 3'd6, UN_NEG  = 3'd7
  } unary_e;

  typedef enum logic [2:0] {
    RG_ADD = 3'd0, RG_SUB = 3'd1, RG_AND = 3'd2, RG_OR  = 3'd3,
    RG_XOR = 3'd4, RG_SHL = 3'd5, RG_SHR = 3'd6, RG_SAR = 3'd7
  } regop_e;

  localparam int IMM_W = 8;
endpackage

// File: rtl/acc_alu_unary.sv
module acc_alu_unary
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] acc,
  input  logic [2:0]   fn,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (unary_e'(fn))
      UN_ZERO: res = '0;
      UN_SHL1: res = {acc[W-2:0], 1'b0};
      UN_SHR1: res = {1'b0, acc[W-1:1]};
      UN_SAR1: res = {acc[W-1], acc[W-1:1]};
      UN_INC:  res = acc + W'(1);
      UN_DEC:  res = acc - W'(1);
      UN_NOT:  res = ~acc;
      default: res = W'(0) - acc;
    endcase
  end
endmodule

// File: rtl/acc_alu_regop.sv
module acc_alu_regop
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  input  logic [2:0]   fn,
  output logic [W-1:0] res,
  output logic [W-1:0] lt
);
  localparam int SHW = (W > 1) ? $clog2(W) : 1;

  logic          over;
  logic [SHW-1:0] amt;

  assign over = ({1'b0, opnd} >= (W+1)'(W));
  assign amt  = opnd[SHW-1:0];
  assign lt   = W'(acc < opnd);

  always_comb begin
    unique case (regop_e'(fn))
      RG_ADD: res = acc + opnd;
      RG_SUB: res = acc - opnd;
      RG_AND: res = acc & opnd;
      RG_OR:  res = acc | opnd;
      RG_XOR: res = acc ^ opnd;
      RG_SHL: res = over ? '0 : (acc << amt);
      RG_SHR: res = over ? '0 : (acc >> amt);
      default: res = over ? {W{acc[W-1]}} : W'($signed(acc) >>> amt);
    endcase
  end
endmodule

// File: rtl/acc_alu_immop.sv
module acc_alu_immop
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]     acc,
  input  logic [1:0]       fn,
  input  logic [IMM_W-1:0] imm,
  output logic [W-1:0]     res
);
  logic [W-1:0]   zimm, add7, add6, shres;
  logic [2*W-1:0] dbl;
  logic [2:0]     amt;

  assign zimm = W'(imm);
  assign add7 = acc + W'(imm[6:0]);
  assign add6 = acc + W'($signed(imm[5:0]));
  assign amt  = imm[2:0];
  assign dbl  = {acc, acc} << amt;

  always_comb begin
    unique case (imm[4:3])
      2'd0: shres = dbl[2*W-1:W];
      2'd1: shres = acc << amt;
      2'd2: shres = acc >> amt;
      default: shres = W'($signed(acc) >>> amt);
    endcase
  end

  always_comb begin
    unique case (fn)
      2'd0: res = acc & zimm;
      2'd1: res = acc | zimm;
      2'd2: res = acc ^ zimm;
      default: begin
        if (!imm[7])            res = add7;
        else if (imm[6])        res = add6;
        else if (!imm[5])       res = shres;
        else                    res = acc;
      end
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [1:0]       grp_i,
  input  logic [2:0]       fn_i,
  input  logic [W-1:0]     acc_i,
  input  logic [W-1:0]     opnd_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [W-1:0]     res_o,
  output logic             res_valid_o
);
  logic [W-1:0] un_res, rg_res, lt_res, im_res, nxt;

  generate
    if (W < IMM_W) begin : g_bad_width
      initial $error("acc_alu: W must be at least the immediate width");
    end
  endgenerate

  acc_alu_unary #(.W(W)) u_unary (.acc(acc_i), .fn(fn_i), .res(un_res));
  acc_alu_regop #(.W(W)) u_regop (.acc(acc_i), .opnd(opnd_i), .fn(fn_i),
                                  .res(rg_res), .lt(lt_res));
  acc_alu_immop #(.W(W)) u_immop (.acc(acc_i), .fn(fn_i[1:0]), .imm(imm_i),
                                  .res(im_res));

  always_comb begin
    unique case (grp_e'(grp_i))
      GRP_UNARY: nxt = un_res;
      GRP_REG:   nxt = rg_res;
      GRP_CMP:   nxt = lt_res;
      default:   nxt = im_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o       <= '0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= valid_i;
      if (valid_i) res_o <= nxt;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (res_o == '0 && !res_valid_o));

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> res_valid_o);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!res_valid_o && $stable(res_o)));

  p_zero_op_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_i && grp_i == GRP_UNARY && fn_i == UN_ZERO) |=> res_o == '0);

  p_cmp_bool_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_i && grp_i == GRP_CMP) |=> res_o <= W'(1));

  p_cmp_equal_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_i && grp_i == GRP_CMP && acc_i == opnd_i) |=> res_o == '0);

  p_unused_pass_r11: assert property (@(posedge clk) disable iff (rst)
    (valid_i && grp_i == GRP_IMM && fn_i[1:0] == 2'd3 && imm_i[7:5] == 3'b101)
      |=> res_o == $past(acc_i));
endmodule

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         valid_i = 1'b0;
  logic [1:0]   grp_i = '0;
  logic [2:0]   fn_i = '0;
  logic [W-1:0] acc_i = '0, opnd_i = '0;
  logic [7:0]   imm_i = '0;
  logic [W-1:0] res_o;
  logic         res_valid_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  acc_alu #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .valid_i(valid_i), .grp_i(grp_i), .fn_i(fn_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .imm_i(imm_i),
    .res_o(res_o), .res_valid_o(res_valid_o));

  function automatic logic [W-1:0] model(input logic [1:0] g, input logic [2:0] f,
      input logic [W-1:0] a, input logic [W-1:0] b, input logic [7:0] im);
    int ai, bi, sh;
    logic [W-1:0] r;
    ai = int'(a); bi = int'(b);
    r = '0;
    case (g)
      2'd0: case (f)
        3'd0: r = 0;
        3'd1: r = W'(ai * 2);
        3'd2: r = W'(ai / 2);
        3'd3: r = W'(ai / 2) | (a & (1 << (W-1)));
        3'd4: r = W'(ai + 1);
        3'd5: r = W'(ai + (1 << W) - 1);
        3'd6: r = W'((1 << W) - 1 - ai);
        default: r = W'((1 << W) - ai);
      endcase
      2'd1: case (f)
        3'd0: r = W'(ai + bi);
        3'd1: r = W'(ai - bi + (1 << W));
        3'd2: r = a & b;
        3'd3: r = a | b;
        3'd4: r = a ^ b;
        default: begin
          for (int k = 0; k < W; k++) begin
            sh = (f == 3'd5) ? k - bi : k + bi;
            if (sh >= 0 && sh < W) r[k] = a[sh];
            else if (f == 3'd7 && sh >= W) r[k] = a[W-1];
            else r[k] = 1'b0;
          end
        end
      endcase
      2'd2: r = (ai < bi) ? 1 : 0;
      default: begin
        if (f[1:0] == 2'd0) r = a & W'(im);
        else if (f[1:0] == 2'd1) r = a | W'(im);
        else if (f[1:0] == 2'd2) r = a ^ W'(im);
        else if (im[7] == 1'b0) r = W'(ai + int'(im[6:0]));
        else if (im[6]) r = W'(ai + int'(im[5:0]) - (im[5] ? 64 : 0) + (1 << W));
        else if (im[5]) r = a;
        else begin
          for (int k = 0; k < W; k++) begin
            case (im[4:3])
              2'd0: r[k] = a[(k - int'(im[2:0]) + W) % W];
              2'd1: r[k] = (k - int'(im[2:0]) >= 0) ? a[k - int'(im[2:0])] : 1'b0;
              2'd2: r[k] = (k + int'(im[2:0]) < W) ? a[k + int'(im[2:0])] : 1'b0;
              default: r[k] = (k + int'(im[2:0]) < W) ? a[k + int'(im[2:0])] : a[W-1];
            endcase
          end
        end
      end
    endcase
    return r;
  endfunction

  function automatic string tag(input logic [1:0] g, input logic [2:0] f, input logic [7:0] im);
    if (g == 2'd0) return "R3";
    if (g == 2'd1) return (f >= 3'd5) ? "R5" : "R4";
    if (g == 2'd2) return "R6";
    if (f[1:0] != 2'd3) return "R7";
    if (!im[7]) return "R8";
    if (im[6]) return "R9";
    if (im[5]) return "R11";
    return "R10";
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] g, input logic [2:0] f,
                    input logic [W-1:0] a, input logic [W-1:0] b, input logic [7:0] im);
    @(negedge clk);
    valid_i = 1'b1; grp_i = g; fn_i = f; acc_i = a; opnd_i = b; imm_i = im;
    @(negedge clk);
    valid_i = 1'b0;
    check(tag(g, f, im), res_o, model(g, f, a, b, im));
    check("R2", W'(res_valid_o), W'(1));
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", res_o, '0);
    check("R1", W'(res_valid_o), '0);
    rst = 1'b0;

    // R3 unary corners
    for (int f = 0; f < 8; f++) op(2'd0, 3'(f), 8'h80, 8'h00, 8'h00);
    op(2'd0, 3'd4, 8'hFF, 0, 0);
    op(2'd0, 3'd5, 8'h00, 0, 0);
    op(2'd0, 3'd3, 8'h81, 0, 0);
    // R4
    op(2'd1, 3'd0, 8'hF0, 8'h20, 0);
    op(2'd1, 3'd1, 8'h05, 8'h09, 0);
    // R5 shift limits
    op(2'd1, 3'd5, 8'h81, 8'd8, 0);
    op(2'd1, 3'd6, 8'h81, 8'd200, 0);
    op(2'd1, 3'd7, 8'h81, 8'd8, 0);
    op(2'd1, 3'd7, 8'h41, 8'd255, 0);
    op(2'd1, 3'd7, 8'h90, 8'd7, 0);
    op(2'd1, 3'd6, 8'h90, 8'd0, 0);
    // R6 unsigned compare, half-adder carry
    op(2'd2, 3'd0, 8'h80, 8'h7F, 0);
    op(2'd2, 3'd0, 8'h7F, 8'h80, 0);
    op(2'd2, 3'd0, 8'h33, 8'h33, 0);
    op(2'd2, 3'd0, 8'h10, 8'hF5, 0);
    // R7
    op(2'd3, 3'd0, 8'hF3, 0, 8'h3C);
    op(2'd3, 3'd6, 8'hF3, 0, 8'h3C);
    // R8 / R9
    op(2'd3, 3'd3, 8'h01, 0, 8'h7F);
    op(2'd3, 3'd3, 8'h10, 0, 8'hE0);
    op(2'd3, 3'd3, 8'h10, 0, 8'hFF);
    op(2'd3, 3'd3, 8'h10, 0, 8'hDF);
    // R10 rotate/shift
    op(2'd3, 3'd3, 8'h81, 0, 8'b100_00_000);
    op(2'd3, 3'd3, 8'h81, 0, 8'b100_00_111);
    op(2'd3, 3'd3, 8'hC3, 0, 8'b100_01_011);
    op(2'd3, 3'd3, 8'hC3, 0, 8'b100_10_011);
    op(2'd3, 3'd3, 8'hC3, 0, 8'b100_11_111);
    // R11 unused encoding
    op(2'd3, 3'd3, 8'h5A, 8'hFF, 8'b101_10101);

    // R2 hold while idle
    @(negedge clk);
    acc_i = 8'h11; opnd_i = 8'h22; grp_i = 2'd1; fn_i = 3'd0;
    @(negedge clk);
    check("R2", res_o, model(2'd3, 3'd3, 8'h5A, 8'hFF, 8'b101_10101));
    check("R2", W'(res_valid_o), '0);

    // random
    for (int i = 0; i < 600; i++) begin
      logic [1:0] g; logic [2:0] f; logic [W-1:0] a, b; logic [7:0] im;
      g = 2'($urandom); f = 3'($urandom); a = W'($urandom); b = W'($urandom);
      im = 8'($urandom);
      if (g == 2'd1 && f >= 3'd5 && ($urandom % 2) == 0) b = W'($urandom % 10);
      op(g, f, a, b, im);
    end

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1; valid_i = 1'b1;
    @(negedge clk);
    check("R1", res_o, '0);
    check("R1", W'(res_valid_o), '0);
    rst = 1'b0; valid_i = 1'b0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule